// File: doc/BRIEF.md
# Scripted Display Bring-Up Sequencer

This block walks a script of 48-bit words held in an external read-only array. It uses the script to power up, reset, configure and clear a serial display controller. Each word drives a small set of board-level controls: two active-low supply enables, an active-low panel reset and a data/command select. It also drives the write and read strobes and the data byte of a byte-wide SPI master. Besides those controls, a word carries an execution time, a signed relative jump offset and a flag that stalls the script until the SPI master is idle.

A free-running cycle counter starts when the synchronised reset is released. A word takes effect only once the counter has reached that word's time, so power and reset delays live in the script and not in the logic. Counted loops are built from a word that loads a repeat counter and a later word that jumps backwards. A zero offset parks the sequencer for good. The SPI master itself sits outside the block; only its byte, its strobes and its busy flag cross the boundary.

Top module: `seq_bringup`

## Requirements
- R1: A word is laid out, most significant bit first, as jump offset [47:44], execution time [43:16], data byte [15:8] and control bits [7:0]. Bit 7 is load, bit 6 is logic supply off, bit 5 is panel supply off, bit 4 is panel reset released, bit 3 is data/command select, bit 2 is write strobe, bit 1 is read strobe and bit 0 is wait-for-SPI. When a non-load word executes, bits 6..1 drive logic_pwr_n, panel_pwr_n, panel_rst_n, dc_sel, spi_wr and spi_rd, and the data byte drives spi_byte, from the next clock edge.
- R2: During and right after reset, rom_addr is 0, spi_byte is 0, logic_pwr_n, panel_pwr_n and panel_rst_n are 1, dc_sel, spi_wr and spi_rd are 0, and stopped is 0.
- R3: The time counter reads 0 on the first active edge after the two-stage reset release and then counts up by one per cycle. A word executes on the first edge at which the counter is at or past its time; until then rom_addr and all outputs hold.
- R4: A jump offset of +1 moves to the next word, and positive offsets up to +7 skip forward by that many words without executing the skipped words.
- R5: A jump offset of 0 executes the word and then asserts stopped; rom_addr and all outputs then hold for good.
- R6: A word with bit 7 set loads the 15-bit repeat count {word[6:0], word[15:8]} and leaves every output unchanged.
- R7: A negative two's-complement offset (-1 to -7) jumps back while the repeat count is above 1, and each such jump decrements the count. Otherwise execution falls through to the next word, decrementing a non-zero count. A loop body therefore runs N times for a count N of at least 1, and once for a count of 0.
- R8: A word with bit 0 set applies its outputs and, from the following cycle, holds rom_addr until spi_busy is sampled low. Only then does it take its jump.
- R9: A complete bring-up script sends its command bytes with dc_sel low in script order, sends 512 data bytes of FFh with dc_sel high, alternates write and read strobes, and ends with stopped asserted.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_addr | output | ADDR_W | Address of the current script word |
| rom_word | input | 48 | Script word at rom_addr, combinational read |
| spi_busy | input | 1 | SPI master transfer in progress |
| spi_byte | output | 8 | Byte presented to the SPI master |
| spi_wr | output | 1 | Write strobe to the SPI master |
| spi_rd | output | 1 | Read strobe to the SPI master |
| dc_sel | output | 1 | Data (1) or command (0) select |
| logic_pwr_n | output | 1 | Logic supply enable, active low |
| panel_pwr_n | output | 1 | Panel supply enable, active low |
| panel_rst_n | output | 1 | Panel reset, active low |
| stopped | output | 1 | Script has reached its terminal word |

## Verification
The hardest situation to reach is a wait word that stays stalled over many cycles while busy is held high. The same goes for the exact edge at which a timed word fires, because both hinge on counting register stages from reset release. The bench drives busy by hand for the stall case and counts edges after a reset released on a falling edge for the timed case. For loop boundaries, a table of repeat counts (0, 1, small and several hundred) is combined with every backward offset from -1 to -7. A full script runs against an SPI model with random busy latency.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int OFF_W  = 4;
  localparam int TIME_W = 28;
  localparam int DATA_W = 8;
  localparam int CTRL_W = 8;
  localparam int CNT_W  = 15;
  localparam int WORD_W = OFF_W + TIME_W + DATA_W + CTRL_W;
  localparam int CNT_HI_W = CNT_W - DATA_W;

  typedef struct packed {
    logic load;
    logic vdd_n;
    logic vbat_n;
    logic res_n;
    logic dc;
    logic wr;
    logic rd;
    logic wait_spi;
  } ctrl_t;

  typedef struct packed {
    logic [OFF_W-1:0]  off;
    logic [TIME_W-1:0] t;
    logic [DATA_W-1:0] data;
    ctrl_t             ctrl;
  } word_t;

  typedef struct packed {
    logic vdd_n;
    logic vbat_n;
    logic res_n;
    logic dc;
    logic wr;
    logic rd;
  } drive_t;

  localparam drive_t DRIVE_RST = '{vdd_n: 1'b1, vbat_n: 1'b1, res_n: 1'b1,
                                   dc: 1'b0, wr: 1'b0, rd: 1'b0};

  typedef enum logic [1:0] {ST_RUN, ST_WAIT, ST_STOP} st_e;

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/seq_timebase.sv
module seq_timebase #(
  parameter int TIME_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [TIME_W-1:0] tick
);
  localparam logic [TIME_W-1:0] TICK_MAX = '1;

  logic [TIME_W-1:0] tick_q;
  logic [TIME_W-1:0] tick_d;
  logic              tick_en;

  always_comb begin
    tick_en = (tick_q != TICK_MAX);
    tick_d  = tick_q + TIME_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tick_q <= '0;
    else if (tick_en) tick_q <= tick_d;
  end

  assign tick = tick_q;

  // R3
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q != TICK_MAX) |=> (tick_q == $past(tick_q) + TIME_W'(1)));
endmodule

// File: rtl/seq_loop_ctr.sv
module seq_loop_ctr #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec_en,
  output logic             more,
  output logic             nonzero
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_en || dec_en;
    cnt_d  = load_en ? load_val : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign more    = (cnt_q > CNT_W'(1));
  assign nonzero = (cnt_q != '0);

  // R6
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cnt_q == $past(load_val)));

  // R7
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !load_en) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !load_en) |-> nonzero);
endmodule

// File: rtl/seq_pc.sv
module seq_pc #(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jump_en,
  input  logic [OFF_W-1:0]  off,
  input  logic              rep_more,
  output logic [ADDR_W-1:0] pc,
  output logic              back_jump,
  output logic              stop_hit
);
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;
  logic [ADDR_W-1:0] off_ext;
  logic              is_back;
  logic              is_zero;

  always_comb begin
    off_ext   = {{(ADDR_W-OFF_W){off[OFF_W-1]}}, off};
    is_back   = off[OFF_W-1];
    is_zero   = (off == '0);
    back_jump = jump_en && is_back;
    stop_hit  = jump_en && is_zero;
    pc_d      = pc_q;
    if (jump_en && !is_zero) begin
      if (is_back && !rep_more) pc_d = pc_q + ADDR_W'(1);
      else                      pc_d = pc_q + off_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_q <= '0;
    else if (jump_en) pc_q <= pc_d;
  end

  assign pc = pc_q;

  // R4
  fwd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_en && off == OFF_W'(1)) |=> (pc_q == $past(pc_q) + ADDR_W'(1)));

  // R7
  fall_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_en && is_back && !rep_more) |=> (pc_q == $past(pc_q) + ADDR_W'(1)));
endmodule

// File: rtl/seq_bringup.sv
module seq_bringup
  import seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [WORD_W-1:0] rom_word,
  input  logic              spi_busy,
  output logic [DATA_W-1:0] spi_byte,
  output logic              spi_wr,
  output logic              spi_rd,
  output logic              dc_sel,
  output logic              logic_pwr_n,
  output logic              panel_pwr_n,
  output logic              panel_rst_n,
  output logic              stopped
);
  logic              rst_int_n;
  logic [TIME_W-1:0] tick;
  word_t             w;
  logic [CTRL_W-1:0] ctrl_bits;
  st_e               state_q, state_d;
  drive_t            drive_q, drive_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic              due, exec_now, release_now, jump_en, apply;
  logic              rep_more, rep_nonzero, back_jump, stop_hit;
  logic              load_en, dec_en;
  logic [CNT_W-1:0]  load_val;
  logic [ADDR_W-1:0] pc;

  seq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_int_n));

  seq_timebase #(.TIME_W(TIME_W)) u_time (
    .clk(clk), .rst_n(rst_int_n), .tick(tick));

  always_comb begin
    w         = word_t'(rom_word);
    ctrl_bits = w.ctrl;
    due       = (tick >= w.t);
    exec_now    = (state_q == ST_RUN) && due;
    release_now = (state_q == ST_WAIT) && !spi_busy;
    jump_en     = (exec_now && !w.ctrl.wait_spi) || release_now;
    apply       = exec_now && !w.ctrl.load;
    load_en     = exec_now && w.ctrl.load;
    load_val    = {ctrl_bits[CNT_HI_W-1:0], w.data};
    dec_en      = back_jump && rep_nonzero;
  end

  seq_loop_ctr #(.CNT_W(CNT_W)) u_loop (
    .clk(clk), .rst_n(rst_int_n), .load_en(load_en), .load_val(load_val),
    .dec_en(dec_en), .more(rep_more), .nonzero(rep_nonzero));

  seq_pc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_pc (
    .clk(clk), .rst_n(rst_int_n), .jump_en(jump_en), .off(w.off),
    .rep_more(rep_more), .pc(pc), .back_jump(back_jump), .stop_hit(stop_hit));

  always_comb begin
    state_d = state_q;
    if (exec_now && w.ctrl.wait_spi) state_d = ST_WAIT;
    else if (jump_en)                state_d = stop_hit ? ST_STOP : ST_RUN;
    drive_d = drive_q;
    byte_d  = byte_q;
    if (apply) begin
      drive_d = '{vdd_n: w.ctrl.vdd_n, vbat_n: w.ctrl.vbat_n, res_n: w.ctrl.res_n,
                  dc: w.ctrl.dc, wr: w.ctrl.wr, rd: w.ctrl.rd};
      byte_d  = w.data;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_RUN;
    else            state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      drive_q <= DRIVE_RST;
      byte_q  <= '0;
    end else if (apply) begin
      drive_q <= drive_d;
      byte_q  <= byte_d;
    end
  end

  assign rom_addr    = pc;
  assign spi_byte    = byte_q;
  assign spi_wr      = drive_q.wr;
  assign spi_rd      = drive_q.rd;
  assign dc_sel      = drive_q.dc;
  assign logic_pwr_n = drive_q.vdd_n;
  assign panel_pwr_n = drive_q.vbat_n;
  assign panel_rst_n = drive_q.res_n;
  assign stopped     = (state_q == ST_STOP);

  // R1
  apply_byte_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    apply |=> (spi_byte == $past(w.data) && dc_sel == $past(w.ctrl.dc)));

  // R3
  early_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_RUN && !due) |=> ($stable(rom_addr) && $stable(drive_q) && $stable(spi_byte)));

  // R5
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    stopped |=> (stopped && $stable(rom_addr) && $stable(drive_q) && $stable(spi_byte)));

  // R6
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    load_en |=> ($stable(drive_q) && $stable(spi_byte)));

  // R8
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_WAIT && spi_busy) |=> ($stable(rom_addr) && state_q == ST_WAIT));
endmodule

// File: tb/tb_seq_bringup.sv
module tb_seq_bringup;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [AW-1:0] rom_addr;
  logic [47:0] rom [256];
  logic [47:0] rom_word;
  logic        spi_busy, man_busy = 1'b0, model_busy = 1'b0, auto_spi = 1'b0;
  logic [2:0]  lat = '0;
  logic [7:0]  spi_byte;
  logic        spi_wr, spi_rd, dc_sel, logic_pwr_n, panel_pwr_n, panel_rst_n, stopped;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic mon_clr = 1'b1;
  logic prev_wr = 1'b0, prev_rd = 1'b0, expect_wr = 1'b1;
  int   n_wr = 0, n_data = 0, n_cmd = 0, order_err = 0;
  logic [7:0] cmd_log [8];
  logic [255:0] seen = '0;

  always #2.5 clk = ~clk;

  assign rom_word = rom[rom_addr];
  assign spi_busy = auto_spi ? model_busy : man_busy;

  seq_bringup #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_word(rom_word),
    .spi_busy(spi_busy), .spi_byte(spi_byte), .spi_wr(spi_wr), .spi_rd(spi_rd),
    .dc_sel(dc_sel), .logic_pwr_n(logic_pwr_n), .panel_pwr_n(panel_pwr_n),
    .panel_rst_n(panel_rst_n), .stopped(stopped));

  // SPI model with random busy latency
  always @(posedge clk) begin
    if (!auto_spi) begin
      model_busy <= 1'b0;
      lat <= '0;
    end else if (model_busy) begin
      if (lat == 0) model_busy <= 1'b0;
      else          lat <= lat - 3'd1;
    end else if (spi_wr) begin
      model_busy <= 1'b1;
      lat <= 3'($urandom_range(0, 5));
    end
  end

  // strobe monitor
  always @(negedge clk) begin
    if (mon_clr) begin
      prev_wr <= 1'b0; prev_rd <= 1'b0; expect_wr <= 1'b1;
      n_wr <= 0; n_data <= 0; n_cmd <= 0; order_err <= 0; seen <= '0;
    end else begin
      prev_wr <= spi_wr;
      prev_rd <= spi_rd;
      seen[spi_byte] <= 1'b1;
      if (spi_wr && !prev_wr) begin
        n_wr <= n_wr + 1;
        if (!expect_wr) order_err <= order_err + 1;
        expect_wr <= 1'b0;
        if (dc_sel && spi_byte == 8'hFF) n_data <= n_data + 1;
        else if (!dc_sel) begin
          if (n_cmd < 8) cmd_log[n_cmd] <= spi_byte;
          n_cmd <= n_cmd + 1;
        end
      end
      if (spi_rd && !prev_rd) begin
        if (expect_wr) order_err <= order_err + 1;
        expect_wr <= 1'b1;
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [47:0] mk(input logic [3:0] off, input logic [27:0] t,
                                     input logic [7:0] d, input logic [7:0] c);
    return {off, t, d, c};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 256; i++) rom[i] = '0;
  endtask

  task automatic start_run();
    rst_n = 1'b0;
    mon_clr = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    mon_clr = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic wait_stop(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (stopped) break;
    end
    @(negedge clk);
  endtask

  // five-word byte write: present, WR, release+wait, RD, release+jump
  task automatic put_byte(input int a, input logic [7:0] d, input logic [7:0] base,
                          input logic [3:0] last_off);
    rom[a]   = mk(4'd1, 28'd0, d, base);
    rom[a+1] = mk(4'd1, 28'd0, d, base | 8'h04);
    rom[a+2] = mk(4'd1, 28'd0, d, base | 8'h01);
    rom[a+3] = mk(4'd1, 28'd0, 8'h00, base | 8'h02);
    rom[a+4] = mk(last_off, 28'd0, 8'h00, base);
  endtask

  // {count[15:0], body length[3:0], expected passes[15:0]}
  localparam logic [35:0] VEC [10] = '{
    {16'd0,   4'd2, 16'd1},   {16'd1,  4'd2, 16'd1},
    {16'd2,   4'd2, 16'd2},   {16'd3,  4'd8, 16'd3},
    {16'd5,   4'd4, 16'd5},   {16'd4,  4'd3, 16'd4},
    {16'd7,   4'd5, 16'd7},   {16'd10, 4'd6, 16'd10},
    {16'd6,   4'd7, 16'd6},   {16'd300,4'd2, 16'd300}};

  initial begin
    // R2 reset state
    clear_rom();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 rom_addr", 32'(rom_addr), 32'd0);
    check("R2 outputs", {spi_byte, logic_pwr_n, panel_pwr_n, panel_rst_n, dc_sel, spi_wr, spi_rd, stopped},
          {8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0});

    // R7 / R6 table walk: loop counts and backward offsets -1..-7
    foreach (VEC[k]) begin
      logic [15:0] cnt; logic [3:0] blen; logic [15:0] exp;
      {cnt, blen, exp} = VEC[k];
      clear_rom();
      rom[0] = mk(4'd1, 28'd0, cnt[7:0], {1'b1, cnt[14:8]});
      rom[1] = mk(4'd1, 28'd0, 8'h21, 8'h14);
      for (int j = 2; j <= int'(blen); j++)
        rom[j] = mk((j == int'(blen)) ? 4'(-(int'(blen) - 1)) : 4'd1, 28'd0, 8'h22, 8'h10);
      rom[blen + 1] = mk(4'd0, 28'd0, 8'h99, 8'h10);
      start_run();
      wait_stop(20000);
      check("R7 loop passes", 32'(n_wr), 32'(exp));
      check("R7 fall-through address", 32'(rom_addr), 32'(blen) + 32'd1);
    end

    // R3 / R1 / R5: timed word with every control bit pattern
    clear_rom();
    rom[0] = mk(4'd0, 28'd20, 8'hAB, 8'h2E);
    start_run();
    repeat (22) @(posedge clk);
    @(negedge clk);
    check("R3 not yet due", {31'd0, dc_sel}, 32'd0);
    check("R3 address held", 32'(rom_addr), 32'd0);
    @(posedge clk); @(negedge clk);
    check("R1 fields applied", {spi_byte, logic_pwr_n, panel_pwr_n, panel_rst_n, dc_sel, spi_wr, spi_rd},
          {8'hAB, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1});
    check("R5 stopped", {31'd0, stopped}, 32'd1);
    repeat (10) @(negedge clk);
    check("R5 hold", {rom_addr, spi_byte, stopped}, {8'd0, 8'hAB, 1'b1});

    // R4 forward +3
    clear_rom();
    rom[0] = mk(4'd3, 28'd0, 8'h01, 8'h10);
    rom[1] = mk(4'd1, 28'd0, 8'h11, 8'h10);
    rom[2] = mk(4'd1, 28'd0, 8'h11, 8'h10);
    rom[3] = mk(4'd0, 28'd0, 8'h33, 8'h10);
    start_run();
    wait_stop(100);
    check("R4 skip +3 target", {rom_addr, spi_byte}, {8'd3, 8'h33});
    check("R4 skipped words unexecuted", {31'd0, seen[8'h11]}, 32'd0);

    // R4 forward +7
    clear_rom();
    rom[0] = mk(4'd7, 28'd0, 8'h01, 8'h10);
    for (int j = 1; j < 7; j++) rom[j] = mk(4'd1, 28'd0, 8'h11, 8'h10);
    rom[7] = mk(4'd0, 28'd0, 8'h77, 8'h10);
    start_run();
    wait_stop(100);
    check("R4 skip +7 target", {rom_addr, spi_byte, seen[8'h11]}, {8'd7, 8'h77, 1'b0});

    // R6 load word leaves outputs, count = {word[6:0], byte} = 259
    clear_rom();
    rom[0] = mk(4'd1, 28'd0, 8'h5A, 8'h18);
    rom[1] = mk(4'd1, 28'd0, 8'h03, 8'h81);
    rom[2] = mk(4'd1, 28'd60, 8'h10, 8'h1C);
    rom[3] = mk(4'hF, 28'd0, 8'h10, 8'h18);
    rom[4] = mk(4'd0, 28'd0, 8'hEE, 8'h18);
    start_run();
    repeat (30) @(negedge clk);
    check("R6 outputs untouched by load", {rom_addr, spi_byte, dc_sel, spi_wr, logic_pwr_n, panel_rst_n},
          {8'd2, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b1});
    wait_stop(5000);
    check("R6 loaded count 259", 32'(n_wr), 32'd259);
    check("R6 stop byte", 32'(spi_byte), 32'hEE);

    // R8 wait stall under manual busy
    clear_rom();
    rom[0] = mk(4'd1, 28'd0, 8'hC3, 8'h14);
    rom[1] = mk(4'd1, 28'd0, 8'hC3, 8'h11);
    rom[2] = mk(4'd1, 28'd0, 8'h00, 8'h12);
    rom[3] = mk(4'd0, 28'd0, 8'h00, 8'h10);
    man_busy = 1'b1;
    start_run();
    repeat (30) @(negedge clk);
    check("R8 stalled", {rom_addr, spi_rd, spi_wr, spi_byte}, {8'd1, 1'b0, 1'b0, 8'hC3});
    man_busy = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R8 released address", {rom_addr, spi_rd}, {8'd2, 1'b0});
    @(posedge clk); @(negedge clk);
    check("R8 next word applied", {spi_rd, spi_byte}, {1'b1, 8'h00});

    // R9 complete bring-up script with random busy latency
    clear_rom();
    rom[0] = mk(4'd1, 28'd0,  8'h00, 8'h70);
    rom[1] = mk(4'd1, 28'd4,  8'h00, 8'h30);
    rom[2] = mk(4'd1, 28'd10, 8'h00, 8'h20);
    rom[3] = mk(4'd1, 28'd16, 8'h00, 8'h30);
    put_byte(4,  8'h8D, 8'h30, 4'd1);
    put_byte(9,  8'h14, 8'h30, 4'd1);
    put_byte(14, 8'hD9, 8'h30, 4'd1);
    rom[19] = mk(4'd1, 28'd120, 8'h00, 8'h10);
    rom[20] = mk(4'd1, 28'd0, 8'h00, 8'h82);
    put_byte(21, 8'hFF, 8'h18, 4'hC);
    put_byte(26, 8'hAF, 8'h10, 4'd1);
    rom[31] = mk(4'd0, 28'd0, 8'h00, 8'h10);
    auto_spi = 1'b1;
    start_run();
    wait_stop(40000);
    check("R9 data writes with dc high", 32'(n_data), 32'd512);
    check("R9 command count", 32'(n_cmd), 32'd4);
    check("R9 command order", {cmd_log[0], cmd_log[1], cmd_log[2], cmd_log[3]}, 32'h8D14D9AF);
    check("R9 strobe alternation errors", 32'(order_err), 32'd0);
    check("R9 stop reached", {rom_addr, stopped}, {8'd31, 1'b1});
    auto_spi = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule